// File: doc/BRIEF.md
# Static Memory Bus to Wishbone Bridge

This block sits in an FPGA next to an external processor and serves that processor's asynchronous static-memory bus. It decodes six active-low chip selects and turns each external access into a single Wishbone transfer on one of two master ports. One port serves memory and carries a wide address. The other serves peripheral I/O and carries a narrower address. The chip-select, output-enable and write-enable inputs pass through a synchroniser first. Once a chip select is active together with a read or write strobe, the bridge captures the address, the byte lanes and the write data. It then raises CYC and STB on the selected port and pulls the active-low wait line low, so the external controller stalls until the slave acknowledges.

On a read, the acknowledged data is held in a register. It is offered on the shared data bus through an output-enable flag only while the external output enable and a chip select are both active. The bridge issues one transfer per chip-select assertion and waits for every chip select to go inactive before it accepts the next one. Alongside the bus, it forwards a few interrupt lines to the external device and passes the system reset on as an active-low reset to the device and as an active-high reset to the Wishbone slaves.

Top module: `smc_wb_bridge`

## Requirements
- R1: While `rst_i` is high, `sm_rst_n_o` is 0, `mem_rst_o` and `io_rst_o` are 1, both CYC outputs are 0, `sm_wait_n_o` is 1 and `sm_data_oe_o` is 0. After reset releases, `sm_rst_n_o` is 1 and both Wishbone resets are 0.
- R2: `sm_irq_o` equals bits 4..0 of `irq_i`, and bits 31..5 of `irq_i` have no effect on it.
- R3: The lowest-numbered active chip select (bit i of `sm_cs_n_i` low) picks the port. Indices 0 to 3 pick the memory port and indices 4 and 5 pick the I/O port. The port that is not picked keeps CYC and STB at 0.
- R4: `mem_adr_o` is the 26-bit external address zero-extended to 32 bits. `io_adr_o` is bits 23..0 of the external address.
- R5: `sm_we_n_i` = 0 gives a write, with WE = 1 and DAT_O equal to `sm_data_i`. `sm_we_n_i` = 1 with `sm_oe_n_i` = 0 gives a read, with WE = 0.
- R6: SEL is the bitwise inverse of `sm_lane_n_i`. SEL bit 0 covers data bits 7..0 and SEL bit 3 covers data bits 31..24.
- R7: CYC and STB rise on the third rising clock edge after a chip select and a strobe are applied together. A chip select with both `sm_oe_n_i` and `sm_we_n_i` high starts no transfer.
- R8: `sm_wait_n_o` is 0 for as long as CYC is high. On the clock edge that samples ACK, CYC and STB drop and `sm_wait_n_o` returns to 1. ADR, SEL, WE and DAT_O stay constant until ACK.
- R9: One transfer is issued per chip-select assertion. Holding the chip select and strobe after ACK starts nothing more until all chip selects have gone high.
- R10: Read data is captured on ACK and driven as `sm_data_o` with `sm_data_oe_o` = 1 only while the synchronised output enable and a chip select are active. A write, or the output enable going high, leaves `sm_data_oe_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_i | input | 32 | Interrupt sources |
| sm_irq_o | output | 5 | Interrupts forwarded to the external device, active high |
| sm_rst_n_o | output | 1 | Reset to the external device, active low |
| sm_cs_n_i | input | 6 | External chip selects, active low |
| sm_oe_n_i | input | 1 | External output enable, active low |
| sm_we_n_i | input | 1 | External write enable, active low (0 = write) |
| sm_lane_n_i | input | 4 | External byte-lane enables, active low |
| sm_addr_i | input | 26 | External address |
| sm_data_i | input | 32 | Shared data bus, value seen at the FPGA |
| sm_data_o | output | 32 | Read data for the shared bus |
| sm_data_oe_o | output | 1 | Drive enable for the shared bus |
| sm_wait_n_o | output | 1 | Wait request to the external controller, active low |
| mem_cyc_o | output | 1 | Memory port CYC |
| mem_stb_o | output | 1 | Memory port STB |
| mem_we_o | output | 1 | Memory port WE |
| mem_sel_o | output | 4 | Memory port SEL |
| mem_adr_o | output | 32 | Memory port address |
| mem_dat_o | output | 32 | Memory port write data |
| mem_dat_i | input | 32 | Memory port read data |
| mem_ack_i | input | 1 | Memory port ACK |
| mem_rst_o | output | 1 | Memory slave reset, active high |
| io_cyc_o | output | 1 | I/O port CYC |
| io_stb_o | output | 1 | I/O port STB |
| io_we_o | output | 1 | I/O port WE |
| io_sel_o | output | 4 | I/O port SEL |
| io_adr_o | output | 24 | I/O port address |
| io_dat_o | output | 32 | I/O port write data |
| io_dat_i | input | 32 | I/O port read data |
| io_ack_i | input | 1 | I/O port ACK |
| io_rst_o | output | 1 | I/O slave reset, active high |

## Verification
The bench sweeps all six chip selects against all sixteen byte-lane patterns, in both directions and with several ACK delays. This catches a design that routes select 3 or 4 to the wrong port, that forgets to invert the lane enables, or that reverses the write sense, since each of these shows up as a wrong SEL, WE or port. Chip selects that are active at the same time expose a design that decodes the highest index instead of the lowest. Holding the chip select after ACK exposes a bridge that issues a second transfer, and the exact count of launch cycles exposes an extra or missing synchroniser stage. Dropping the output enable while the chip select is still held, and checking a write, catch a data driver that stays on the shared bus when it should release it.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int EXT_AW = 26;
    localparam int DW     = 32;
    localparam int SEL_W  = DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } smb_state_e;

    typedef struct packed {
        logic              is_io;
        logic              write;
        logic [SEL_W-1:0]  sel;
        logic [EXT_AW-1:0] addr;
        logic [DW-1:0]     wdata;
    } smb_req_t;

    function automatic logic [SEL_W-1:0] lanes_to_sel(input logic [SEL_W-1:0] lane_n);
        return ~lane_n;
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
    end

    assign q_o = chain_q[CHAIN_W-1 -: W];

    initial begin
        a_stage_count: assert (STAGES >= 2);
    end
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_pkg::*;
#(
    parameter int NCS    = 6,
    parameter int MEM_CS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NCS-1:0]    cs_n_s_i,
    input  logic              oe_n_s_i,
    input  logic              we_n_s_i,
    input  logic [EXT_AW-1:0] addr_i,
    input  logic [DW-1:0]     data_i,
    input  logic [SEL_W-1:0]  lane_n_i,
    input  logic              mem_ack_i,
    input  logic              io_ack_i,
    input  logic [DW-1:0]     mem_dat_i,
    input  logic [DW-1:0]     io_dat_i,
    output smb_req_t          req_o,
    output logic              busy_o,
    output logic [DW-1:0]     rdata_o,
    output logic              data_oe_o
);
    smb_state_e st_q;
    smb_req_t   req_q;
    logic [DW-1:0] rdata_q;
    logic       rvld_q;

    logic cs_any;
    logic strobe;
    logic pick_io;
    logic ack_sel;
    logic [DW-1:0] rd_sel;

    assign cs_any = ~&cs_n_s_i;
    assign strobe = ~oe_n_s_i | ~we_n_s_i;

    // lowest-numbered active select decides the port
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_io = 1'b1;
        for (int i = 0; i < NCS; i++) begin
            if (!found && !cs_n_s_i[i]) begin
                found   = 1'b1;
                pick_io = (i >= MEM_CS);
            end
        end
    end

    assign ack_sel = req_q.is_io ? io_ack_i : mem_ack_i;
    assign rd_sel  = req_q.is_io ? io_dat_i : mem_dat_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
            rvld_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    rvld_q <= 1'b0;
                    if (cs_any && strobe) begin
                        st_q        <= ST_BUSY;
                        req_q.is_io <= pick_io;
                        req_q.write <= ~we_n_s_i;
                        req_q.sel   <= lanes_to_sel(lane_n_i);
                        req_q.addr  <= addr_i;
                        req_q.wdata <= data_i;
                    end
                end
                ST_BUSY: begin
                    if (ack_sel) begin
                        st_q <= ST_DONE;
                        if (!req_q.write) begin
                            rdata_q <= rd_sel;
                            rvld_q  <= 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (!cs_any) begin
                        st_q   <= ST_IDLE;
                        rvld_q <= 1'b0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_o     = req_q;
    assign busy_o    = (st_q == ST_BUSY);
    assign rdata_o   = rdata_q;
    assign data_oe_o = rvld_q & ~oe_n_s_i & cs_any;

    // R8: request fields hold until the selected slave acknowledges
    p_req_stable_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !ack_sel) |=> $stable(req_q));

    // R8: an acknowledge ends the transfer on the next edge
    p_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && ack_sel) |=> (!busy_o && st_q == ST_DONE));

    // R9: a served select never relaunches directly
    p_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_DONE) |=> !busy_o);

    // R7: a launch needs a select together with a strobe
    p_launch_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(cs_any && strobe));

    // R10: a write never leads to driving the shared bus
    p_no_drive_write_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && req_q.write) |=> !data_oe_o);
endmodule

// File: rtl/smc_wb_bridge.sv
module smc_wb_bridge
    import smb_pkg::*;
#(
    parameter int NCS         = 6,
    parameter int MEM_CS      = 4,
    parameter int MEM_AW      = 32,
    parameter int IO_AW       = 24,
    parameter int IRQ_IN      = 32,
    parameter int IRQ_OUT     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [IRQ_IN-1:0]    irq_i,
    output logic [IRQ_OUT-1:0]   sm_irq_o,
    output logic                 sm_rst_n_o,
    input  logic [NCS-1:0]       sm_cs_n_i,
    input  logic                 sm_oe_n_i,
    input  logic                 sm_we_n_i,
    input  logic [SEL_W-1:0]     sm_lane_n_i,
    input  logic [EXT_AW-1:0]    sm_addr_i,
    input  logic [DW-1:0]        sm_data_i,
    output logic [DW-1:0]        sm_data_o,
    output logic                 sm_data_oe_o,
    output logic                 sm_wait_n_o,
    output logic                 mem_cyc_o,
    output logic                 mem_stb_o,
    output logic                 mem_we_o,
    output logic [SEL_W-1:0]     mem_sel_o,
    output logic [MEM_AW-1:0]    mem_adr_o,
    output logic [DW-1:0]        mem_dat_o,
    input  logic [DW-1:0]        mem_dat_i,
    input  logic                 mem_ack_i,
    output logic                 mem_rst_o,
    output logic                 io_cyc_o,
    output logic                 io_stb_o,
    output logic                 io_we_o,
    output logic [SEL_W-1:0]     io_sel_o,
    output logic [IO_AW-1:0]     io_adr_o,
    output logic [DW-1:0]        io_dat_o,
    input  logic [DW-1:0]        io_dat_i,
    input  logic                 io_ack_i,
    output logic                 io_rst_o
);
    localparam int CTL_W = NCS + 2;

    logic [CTL_W-1:0] ctl_s;
    logic [NCS-1:0]   cs_n_s;
    logic             oe_n_s;
    logic             we_n_s;
    smb_req_t         req;
    logic             busy;

    smb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({sm_cs_n_i, sm_oe_n_i, sm_we_n_i}),
        .q_o   (ctl_s)
    );

    assign cs_n_s = ctl_s[CTL_W-1:2];
    assign oe_n_s = ctl_s[1];
    assign we_n_s = ctl_s[0];

    smb_ctrl #(.NCS(NCS), .MEM_CS(MEM_CS)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cs_n_s_i  (cs_n_s),
        .oe_n_s_i  (oe_n_s),
        .we_n_s_i  (we_n_s),
        .addr_i    (sm_addr_i),
        .data_i    (sm_data_i),
        .lane_n_i  (sm_lane_n_i),
        .mem_ack_i (mem_ack_i),
        .io_ack_i  (io_ack_i),
        .mem_dat_i (mem_dat_i),
        .io_dat_i  (io_dat_i),
        .req_o     (req),
        .busy_o    (busy),
        .rdata_o   (sm_data_o),
        .data_oe_o (sm_data_oe_o)
    );

    assign mem_cyc_o = busy & ~req.is_io;
    assign mem_stb_o = busy & ~req.is_io;
    assign mem_we_o  = req.write;
    assign mem_sel_o = req.sel;
    assign mem_adr_o = MEM_AW'(req.addr);
    assign mem_dat_o = req.wdata;

    assign io_cyc_o  = busy & req.is_io;
    assign io_stb_o  = busy & req.is_io;
    assign io_we_o   = req.write;
    assign io_sel_o  = req.sel;
    assign io_adr_o  = IO_AW'(req.addr);
    assign io_dat_o  = req.wdata;

    assign sm_wait_n_o = ~busy;
    assign sm_irq_o    = irq_i[IRQ_OUT-1:0];
    assign sm_rst_n_o  = ~rst_i;
    assign mem_rst_o   = rst_i;
    assign io_rst_o    = rst_i;

    // R3: never both ports at once
    p_one_port_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(mem_cyc_o && io_cyc_o));

    // R8: the wait line is held low for the whole transfer
    p_wait_held_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_cyc_o || io_cyc_o) |-> !sm_wait_n_o);
endmodule

// File: tb/sim_smc_wb_bridge.sv
`timescale 1ns/1ps
module sim_smc_wb_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq;
    logic [4:0]  sm_irq;
    logic        sm_rst_n;
    logic [5:0]  cs_n;
    logic        oe_n, we_n;
    logic [3:0]  lane_n;
    logic [25:0] addr;
    logic [31:0] din, dout;
    logic        doe, wait_n;
    logic        mcyc, mstb, mwe, mrst, mack;
    logic [3:0]  msel;
    logic [31:0] madr, mdo, mdi;
    logic        icyc, istb, iwe, irst, iack;
    logic [3:0]  isel;
    logic [23:0] iadr;
    logic [31:0] ido, idi;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    smc_wb_bridge u0 (
        .clk_i(clk), .rst_i(rst), .irq_i(irq), .sm_irq_o(sm_irq), .sm_rst_n_o(sm_rst_n),
        .sm_cs_n_i(cs_n), .sm_oe_n_i(oe_n), .sm_we_n_i(we_n), .sm_lane_n_i(lane_n),
        .sm_addr_i(addr), .sm_data_i(din), .sm_data_o(dout), .sm_data_oe_o(doe),
        .sm_wait_n_o(wait_n),
        .mem_cyc_o(mcyc), .mem_stb_o(mstb), .mem_we_o(mwe), .mem_sel_o(msel),
        .mem_adr_o(madr), .mem_dat_o(mdo), .mem_dat_i(mdi), .mem_ack_i(mack), .mem_rst_o(mrst),
        .io_cyc_o(icyc), .io_stb_o(istb), .io_we_o(iwe), .io_sel_o(isel),
        .io_adr_o(iadr), .io_dat_o(ido), .io_dat_i(idi), .io_ack_i(iack), .io_rst_o(irst)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_io(input logic [5:0] pat);
        for (int i = 0; i < 6; i++) if (!pat[i]) return (i >= 4);
        return 1'b1;
    endfunction

    task automatic access(input logic [5:0] pat, input bit wr, input logic [3:0] ln,
                          input logic [25:0] a, input logic [31:0] d, input int dly);
        bit io;
        bit seen;
        logic [31:0] rd;
        io = exp_io(pat);
        rd = d ^ 32'h5A3C_96E1;
        @(negedge clk);
        addr = a; din = d; lane_n = ln; cs_n = pat;
        we_n = wr ? 1'b0 : 1'b1;
        oe_n = wr ? 1'b1 : 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 no cycle before third edge", {62'd0, mcyc, icyc}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R7 cyc/stb on third edge", {62'd0, (io ? icyc : mcyc), (io ? istb : mstb)}, 64'd3);
        check("R3 other port idle", {63'd0, (io ? mcyc : icyc)}, 64'd0);
        if (io) check("R4 io address", {40'd0, iadr}, {40'd0, a[23:0]});
        else    check("R4 mem address", {32'd0, madr}, {38'd0, a});
        check("R5 write enable", {63'd0, (io ? iwe : mwe)}, {63'd0, wr});
        check("R6 select", {60'd0, (io ? isel : msel)}, {60'd0, ~ln});
        if (wr) check("R5 write data", {32'd0, (io ? ido : mdo)}, {32'd0, d});
        for (int k = 0; k < dly; k++) @(negedge clk);
        check("R8 waiting while busy", {62'd0, (io ? icyc : mcyc), wait_n}, 64'd2);
        if (io) begin iack = 1'b1; idi = rd; end
        else    begin mack = 1'b1; mdi = rd; end
        @(posedge clk);
        @(negedge clk);
        iack = 1'b0; mack = 1'b0;
        check("R8 released after ack", {62'd0, wait_n, (mcyc | icyc)}, 64'd2);
        if (!wr) begin
            check("R10 read drive enable", {63'd0, doe}, 64'd1);
            check("R10 read data", {32'd0, dout}, {32'd0, rd});
        end else begin
            check("R10 no drive on write", {63'd0, doe}, 64'd0);
        end
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mcyc || icyc) seen = 1'b1;
        end
        check("R9 single transfer per select", {63'd0, seen}, 64'd0);
        if (!wr) begin
            oe_n = 1'b1;
            repeat (3) @(negedge clk);
            check("R10 drive off when OE high", {63'd0, doe}, 64'd0);
        end
        cs_n = 6'h3F; oe_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; irq = 32'd0; cs_n = 6'h3F; oe_n = 1'b1; we_n = 1'b1;
        lane_n = 4'hF; addr = '0; din = '0; mack = 1'b0; iack = 1'b0; mdi = '0; idi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs",
              {56'd0, sm_rst_n, mrst, irst, mcyc, icyc, wait_n, doe, 1'b0},
              {56'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {61'd0, sm_rst_n, mrst, irst}, 64'd4);

        for (int k = 0; k < 40; k++) begin
            irq = (k * 32'h9E37_79B1) ^ (32'h1 << (k % 32));
            #1;
            check("R2 interrupt forward", {59'd0, sm_irq}, {59'd0, irq[4:0]});
        end

        // select with no strobe
        @(negedge clk);
        cs_n = 6'b111110;
        repeat (8) @(negedge clk);
        check("R7 no strobe no transfer", {62'd0, mcyc, icyc}, 64'd0);
        cs_n = 6'h3F;
        repeat (4) @(negedge clk);

        for (int c = 0; c < 6; c++)
            for (int ln = 0; ln < 16; ln++)
                for (int w = 0; w < 2; w++)
                    access(~(6'b1 << c), w[0], ln[3:0],
                           26'h2A5_5000 ^ 26'(c << 8) ^ 26'(ln << 2) ^ 26'(w << 20),
                           32'hC0DE_0000 + 32'(c * 256 + ln * 2 + w), ln % 3);

        access(6'b110110, 1'b0, 4'b0000, 26'h3FF_FFFF, 32'h1111_2222, 1); // R3 cs0+cs3
        access(6'b001111, 1'b1, 4'b1100, 26'h3C0_0001, 32'h3333_4444, 2); // R3 cs4+cs5
        access(6'b101011, 1'b1, 4'b0011, 26'h155_5555, 32'h5555_6666, 0); // R3 cs2+cs4
        access(6'b011111, 1'b0, 4'b1110, 26'h0AA_AAAA, 32'h7777_8888, 4); // R3 cs5

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule